// File: doc/BRIEF.md
# Descriptor Reply Sequencer

This block answers host IN requests on the control endpoint by itself. Firmware loads a 16-bit start address and a 16-bit byte count into the block and then sets the start bit. From then on, every IN token makes the sequencer read one packet of at most `MAX_PKT` bytes from descriptor memory and pass the bytes to the transmit path, one byte per cycle. Once a packet is out, the address moves forward and the remaining count drops by the number of bytes in that packet.

The reply stops in one of two ways. The first is when the remaining count reaches zero. The second is when the host issues any token that is not IN, which cuts the reply short. In both cases the block turns its own enable off and raises a sticky IN-acknowledge flag, so firmware sees completion as an ordinary IN-done event. Descriptor memory sits outside the block and is reached through a synchronous read port with one cycle of latency.

Top module: `desc_reply_seq`

## Requirements
- R1: While reset is held, and just after it, replyEn, inAck, descAddr, descSize, memRdEn, txValid, txLast, txShort and txZlp are all 0.
- R2: A register write with regWe high loads regWdata into one byte: regSel 0 is the address low byte, 1 the address high byte, 2 the size low byte and 3 the size high byte. These writes take effect only while replyEn is 0. While replyEn is 1 they leave descAddr and descSize unchanged.
- R3: A write to regSel 4 with regWdata bit 0 set turns replyEn on at that clock edge, provided replyEn was 0.
- R4: A token is presented with tokValid high for one cycle. An IN token (tokKind 0) sampled while the reply waits starts a packet of n = min(descSize, MAX_PKT) bytes. The bytes come from addresses descAddr, descAddr+1, and so on. Byte k appears on txData with txValid high in the cycle after clock edge T+1+k, where T is the edge that sampled the token.
- R5: After a packet of n bytes, descAddr grows by n and descSize shrinks by n, both at edge T+n+1. While the reply is active, descAddr+descSize does not change.
- R6: txLast is high with the final byte of each packet. txShort is high together with txLast when n is less than MAX_PKT.
- R7: An IN token accepted while descSize is 0 produces a one-cycle txZlp pulse after edge T and no data byte. The reply then ends at edge T+1.
- R8: When a packet leaves descSize at 0, replyEn falls and inAck rises at that same edge, T+n+1.
- R9: A token other than IN (OUT = 1, SETUP = 2, other = 3) sampled while the reply waits ends the reply at edge T. replyEn falls, inAck rises, no bytes are sent, and descAddr and descSize keep their values.
- R10: inAck stays set until a write to regSel 5 with regWdata bit 0 set clears it. A write there with bit 0 clear has no effect.
- R11: Tokens sampled while replyEn is 0 are ignored. No read and no transmit activity follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (0..5) |
| regWdata | input | 8 | Register write data |
| tokValid | input | 1 | One-cycle token indication |
| tokKind | input | 2 | Token type: 0 IN, 1 OUT, 2 SETUP, 3 other |
| memRdEn | output | 1 | Descriptor memory read enable |
| memAddr | output | 16 | Descriptor memory read address |
| memRdData | input | 8 | Read data, one cycle after memRdEn |
| txValid | output | 1 | Data byte valid toward the transmit path |
| txData | output | 8 | Data byte |
| txLast | output | 1 | Final byte of the packet |
| txShort | output | 1 | Packet shorter than MAX_PKT (with txLast) |
| txZlp | output | 1 | Zero-length packet request |
| replyEn | output | 1 | Reply active |
| inAck | output | 1 | Sticky IN-acknowledge flag |
| descAddr | output | 16 | Current descriptor address |
| descSize | output | 16 | Remaining byte count |

## Verification
Every result has a fixed due cycle measured from the edge T that samples the token. The first byte shows up one edge after the read it depends on, at T+1. The address and count update two edges after the last read is issued, at T+n+1. A zero-length pulse shows up at T itself, and an early end at T as well. The bench model puts each expected byte and event in a queue stamped with the edge number at which it is due. On the falling edge after every clock it compares all outputs against that queue and against its own copies of the registers. This means a byte or update that arrives one cycle early or one cycle late is caught as a mismatch.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 16;

  localparam logic [2:0] SEL_ADDR_LO = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI = 3'd1;
  localparam logic [2:0] SEL_SIZE_LO = 3'd2;
  localparam logic [2:0] SEL_SIZE_HI = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam logic [2:0] SEL_STAT    = 3'd5;

  typedef enum logic [1:0] {
    TOK_IN    = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_OTHER = 2'd3
  } tokKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startPkt;
    logic issueRd;
    logic sendZlp;
    logic commit;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic sizeZero;
    logic lastIdx;
    logic nextZero;
  } dpStatus_t;
endpackage

// File: rtl/dr_ctrl.sv
module dr_ctrl
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regSel,
  input  logic       regWbit0,
  input  logic       tokValid,
  input  logic [1:0] tokKind,
  input  dpStatus_t  dpStat,
  output ctlStrobe_t stb,
  output logic       replyEn,
  output logic       inAck
);
  typedef enum logic [1:0] {S_OFF, S_WAIT, S_READ, S_COMMIT} state_e;

  state_e st, stNxt;
  logic   endNow;

  always_comb begin
    stNxt  = st;
    stb    = '0;
    endNow = 1'b0;
    case (st)
      S_OFF: begin
        if (regWe && regSel == SEL_CTRL && regWbit0) stNxt = S_WAIT;
      end
      S_WAIT: begin
        if (tokValid) begin
          if (tokKind == TOK_IN) begin
            stb.startPkt = 1'b1;
            if (dpStat.sizeZero) begin
              stb.sendZlp = 1'b1;
              stNxt       = S_COMMIT;
            end else begin
              stNxt = S_READ;
            end
          end else begin
            endNow = 1'b1;
            stNxt  = S_OFF;
          end
        end
      end
      S_READ: begin
        stb.issueRd = 1'b1;
        if (dpStat.lastIdx) stNxt = S_COMMIT;
      end
      S_COMMIT: begin
        stb.commit = 1'b1;
        if (dpStat.nextZero) begin
          endNow = 1'b1;
          stNxt  = S_OFF;
        end else begin
          stNxt = S_WAIT;
        end
      end
      default: stNxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_OFF;
      inAck <= 1'b0;
    end else begin
      st <= stNxt;
      if (endNow) inAck <= 1'b1;
      else if (regWe && regSel == SEL_STAT && regWbit0) inAck <= 1'b0;
    end
  end

  assign replyEn = (st != S_OFF);
endmodule

// File: rtl/dr_data.sv
module dr_data
  import dr_pkg::*;
#(
  parameter int MAX_PKT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              replyEn,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [7:0]        regWdata,
  input  ctlStrobe_t        stb,
  output dpStatus_t         dpStat,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              txValid,
  output logic              txLast,
  output logic              txShort,
  output logic              txZlp,
  output logic [ADDR_W-1:0] descAddr,
  output logic [SIZE_W-1:0] descSize
);
  localparam int LEN_W = $clog2(MAX_PKT + 1);
  localparam logic [LEN_W-1:0]  MAX_L = LEN_W'(MAX_PKT);
  localparam logic [SIZE_W-1:0] MAX_S = SIZE_W'(MAX_PKT);

  logic [LEN_W-1:0] idx, pktLen, minLen;

  assign minLen = (descSize < MAX_S) ? descSize[LEN_W-1:0] : MAX_L;

  assign dpStat.sizeZero = (descSize == '0);
  assign dpStat.lastIdx  = (idx == pktLen - LEN_W'(1));
  assign dpStat.nextZero = (descSize == SIZE_W'(pktLen));

  assign memRdEn = stb.issueRd;
  assign memAddr = descAddr + ADDR_W'(idx);

  // address and size registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
      descSize <= '0;
    end else if (stb.commit) begin
      descAddr <= descAddr + ADDR_W'(pktLen);
      descSize <= descSize - SIZE_W'(pktLen);
    end else if (regWe && !replyEn) begin
      case (regSel)
        SEL_ADDR_LO: descAddr[7:0]  <= regWdata;
        SEL_ADDR_HI: descAddr[15:8] <= regWdata;
        SEL_SIZE_LO: descSize[7:0]  <= regWdata;
        SEL_SIZE_HI: descSize[15:8] <= regWdata;
        default: ;
      endcase
    end
  end

  // packet length and byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      pktLen <= '0;
    end else if (stb.startPkt) begin
      idx    <= '0;
      pktLen <= minLen;
    end else if (stb.issueRd) begin
      idx <= idx + LEN_W'(1);
    end
  end

  // transmit flags aligned with memory read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txLast  <= 1'b0;
      txShort <= 1'b0;
      txZlp   <= 1'b0;
    end else begin
      txValid <= stb.issueRd;
      txLast  <= stb.issueRd && dpStat.lastIdx;
      txShort <= stb.issueRd && dpStat.lastIdx && (pktLen != MAX_L);
      txZlp   <= stb.sendZlp;
    end
  end
endmodule

// File: rtl/desc_reply_seq.sv
module desc_reply_seq
  import dr_pkg::*;
#(
  parameter int MAX_PKT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regSel,
  input  logic [7:0]  regWdata,
  input  logic        tokValid,
  input  logic [1:0]  tokKind,
  output logic        memRdEn,
  output logic [15:0] memAddr,
  input  logic [7:0]  memRdData,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        txLast,
  output logic        txShort,
  output logic        txZlp,
  output logic        replyEn,
  output logic        inAck,
  output logic [15:0] descAddr,
  output logic [15:0] descSize
);
  ctlStrobe_t stb;
  dpStatus_t  dpStat;

  dr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWbit0 (regWdata[0]),
    .tokValid (tokValid),
    .tokKind  (tokKind),
    .dpStat   (dpStat),
    .stb      (stb),
    .replyEn  (replyEn),
    .inAck    (inAck)
  );

  dr_data #(.MAX_PKT(MAX_PKT)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .replyEn  (replyEn),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .stb      (stb),
    .dpStat   (dpStat),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .txValid  (txValid),
    .txLast   (txLast),
    .txShort  (txShort),
    .txZlp    (txZlp),
    .descAddr (descAddr),
    .descSize (descSize)
  );

  assign txData = memRdData;
endmodule

// File: rtl/dr_chk.sv
module dr_chk #(
  parameter int MAX_PKT = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        memRdEn,
  input logic        txValid,
  input logic        txLast,
  input logic        txShort,
  input logic        txZlp,
  input logic        replyEn,
  input logic        inAck,
  input logic [15:0] descAddr,
  input logic [15:0] descSize
);
  localparam int CNT_W = $clog2(MAX_PKT + 1);

  logic [15:0]      sumNow;
  logic [CNT_W-1:0] runCnt;

  assign sumNow = descAddr + descSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (txValid) runCnt <= txLast ? '0 : runCnt + CNT_W'(1);
  end

  // R5: advancing address and shrinking count balance each other
  a_r5_sum_kept: assert property (@(posedge clk) disable iff (!rstN)
    (replyEn && $past(replyEn)) |-> (sumNow == $past(sumNow)));

  // R8 / R9: every end of a reply raises the flag
  a_r8_end_flags: assert property (@(posedge clk) disable iff (!rstN)
    $fell(replyEn) |-> inAck);

  // R4: a byte is presented only after a read one cycle earlier
  a_r4_rd_leads_tx: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(memRdEn));

  // R7: zero-length request never overlaps a data byte
  a_r7_zlp_alone: assert property (@(posedge clk) disable iff (!rstN)
    txZlp |-> !txValid);

  // R6: packet markers only ride on a valid byte
  a_r6_marks_valid: assert property (@(posedge clk) disable iff (!rstN)
    (txLast || txShort) |-> txValid);

  // R4: no packet exceeds the maximum length
  a_r4_pkt_bound: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (int'(runCnt) < MAX_PKT));
endmodule

bind desc_reply_seq dr_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memRdEn  (memRdEn),
  .txValid  (txValid),
  .txLast   (txLast),
  .txShort  (txShort),
  .txZlp    (txZlp),
  .replyEn  (replyEn),
  .inAck    (inAck),
  .descAddr (descAddr),
  .descSize (descSize)
);

// File: tb/sim_desc_reply_seq.sv
`timescale 1ns/1ps
module sim_desc_reply_seq;
  localparam int MAXP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [7:0]  regWdata = 8'd0;
  logic        tokValid = 1'b0;
  logic [1:0]  tokKind = 2'd0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData = 8'd0;
  logic        txValid, txLast, txShort, txZlp, replyEn, inAck;
  logic [7:0]  txData;
  logic [15:0] descAddr, descSize;

  desc_reply_seq #(.MAX_PKT(MAXP)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .tokValid(tokValid), .tokKind(tokKind), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txShort(txShort), .txZlp(txZlp), .replyEn(replyEn), .inAck(inAck),
    .descAddr(descAddr), .descSize(descSize)
  );

  always #4 clk = ~clk;

  int checkCnt = 0;
  int failCnt  = 0;
  int txSeen   = 0;
  bit done     = 1'b0;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return 8'(a * 7 + 3);
  endfunction

  // descriptor memory, one cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= memByte(memAddr);

  task automatic cmp(input string tag, input string name, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int cyc; logic [7:0] d; bit last; bit shrt; bit zlp; } txExp_t;
  txExp_t expQ[$];
  int edgeCnt = 0;
  bit          mEn = 0, mAck = 0, busy = 0;
  logic [15:0] mAddr = 0, mSize = 0;
  int commitAt = 0, pendN = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mAck = 0; busy = 0; mAddr = 0; mSize = 0; expQ.delete();
    end else begin
      bit preEn, preBusy, setNow;
      logic [15:0] preSize;
      edgeCnt++;
      preEn = mEn; preBusy = busy; preSize = mSize; setNow = 0;
      if (busy && edgeCnt == commitAt) begin
        mAddr = mAddr + 16'(pendN);
        mSize = mSize - 16'(pendN);
        busy = 0;
        if (mSize == 0) begin mEn = 0; mAck = 1; setNow = 1; end
      end
      if (tokValid && preEn && !preBusy) begin
        if (tokKind == 2'd0) begin
          int n;
          n = (int'(preSize) < MAXP) ? int'(preSize) : MAXP;
          if (n == 0) expQ.push_back('{edgeCnt, 8'd0, 1'b0, 1'b0, 1'b1});
          for (int k = 0; k < n; k++)
            expQ.push_back('{edgeCnt + 1 + k, memByte(mAddr + 16'(k)),
                             (k == n - 1), (k == n - 1) && (n < MAXP), 1'b0});
          busy = 1; commitAt = edgeCnt + n + 1; pendN = n;
        end else begin
          mEn = 0; mAck = 1; setNow = 1;
        end
      end
      if (regWe) begin
        case (regSel)
          3'd0: if (!preEn) mAddr[7:0]  = regWdata;
          3'd1: if (!preEn) mAddr[15:8] = regWdata;
          3'd2: if (!preEn) mSize[7:0]  = regWdata;
          3'd3: if (!preEn) mSize[15:8] = regWdata;
          3'd4: if (!preEn && regWdata[0]) mEn = 1;
          3'd5: if (regWdata[0] && !setNow) mAck = 0;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit eV, eL, eS, eZ;
      logic [7:0] eD;
      eV = 0; eL = 0; eS = 0; eZ = 0; eD = 0;
      if (expQ.size() > 0 && expQ[0].cyc == edgeCnt) begin
        txExp_t e;
        e = expQ.pop_front();
        eV = !e.zlp; eL = e.last; eS = e.shrt; eZ = e.zlp; eD = e.d;
      end
      if (txValid) txSeen++;
      cmp("R4", "txValid", 32'(txValid), 32'(eV));
      if (eV) cmp("R4", "txData", 32'(txData), 32'(eD));
      cmp("R6", "txLast", 32'(txLast), 32'(eL));
      cmp("R6", "txShort", 32'(txShort), 32'(eS));
      cmp("R7", "txZlp", 32'(txZlp), 32'(eZ));
      cmp("R5", "descAddr", 32'(descAddr), 32'(mAddr));
      cmp("R5", "descSize", 32'(descSize), 32'(mSize));
      cmp("R8", "replyEn", 32'(replyEn), 32'(mEn));
      cmp("R10", "inAck", 32'(inAck), 32'(mAck));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wrReg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic sendTok(input logic [1:0] k);
    @(negedge clk); tokValid = 1'b1; tokKind = k;
    @(negedge clk); tokValid = 1'b0;
  endtask

  task automatic loadDesc(input logic [15:0] a, input logic [15:0] s);
    wrReg(3'd0, a[7:0]); wrReg(3'd1, a[15:8]);
    wrReg(3'd2, s[7:0]); wrReg(3'd3, s[15:8]);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1", "replyEn", 32'(replyEn), 0);
    cmp("R1", "inAck", 32'(inAck), 0);
    cmp("R1", "descAddr", 32'(descAddr), 0);
    cmp("R1", "descSize", 32'(descSize), 0);
    cmp("R1", "txValid", 32'(txValid), 0);
    cmp("R1", "memRdEn", 32'(memRdEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R11: token while disabled is ignored
    seen = txSeen;
    sendTok(2'd0);
    repeat (6) @(negedge clk);
    cmp("R11", "txSeen", 32'(txSeen), 32'(seen));
    cmp("R11", "replyEn", 32'(replyEn), 0);

    // R7: size zero gives a zero-length packet
    loadDesc(16'h0100, 16'd0);
    wrReg(3'd4, 8'h01);
    cmp("R3", "replyEn", 32'(replyEn), 1);
    sendTok(2'd0);
    repeat (4) @(negedge clk);
    cmp("R7", "replyEn", 32'(replyEn), 0);
    cmp("R7", "inAck", 32'(inAck), 1);
    wrReg(3'd5, 8'h00);
    cmp("R10", "inAck kept", 32'(inAck), 1);
    wrReg(3'd5, 8'h01);
    cmp("R10", "inAck cleared", 32'(inAck), 0);

    // exactly one full packet
    loadDesc(16'h0200, 16'd8);
    wrReg(3'd4, 8'h01);
    sendTok(2'd0);
    repeat (14) @(negedge clk);
    cmp("R8", "descAddr", 32'(descAddr), 32'h0208);
    cmp("R8", "descSize", 32'(descSize), 0);
    cmp("R8", "inAck", 32'(inAck), 1);
    wrReg(3'd5, 8'h01);

    // one full plus one short packet; writes during the reply are ignored
    loadDesc(16'h0300, 16'd9);
    wrReg(3'd4, 8'h01);
    wrReg(3'd0, 8'h55);
    wrReg(3'd2, 8'h77);
    cmp("R2", "descAddr", 32'(descAddr), 32'h0300);
    cmp("R2", "descSize", 32'(descSize), 9);
    sendTok(2'd0);
    repeat (14) @(negedge clk);
    cmp("R5", "descAddr", 32'(descAddr), 32'h0308);
    cmp("R5", "descSize", 32'(descSize), 1);
    cmp("R5", "replyEn", 32'(replyEn), 1);
    sendTok(2'd0);
    repeat (8) @(negedge clk);
    cmp("R8", "replyEn", 32'(replyEn), 0);
    cmp("R8", "descAddr", 32'(descAddr), 32'h0309);
    wrReg(3'd5, 8'h01);

    // early end by an OUT token
    loadDesc(16'h0400, 16'd20);
    wrReg(3'd4, 8'h01);
    sendTok(2'd0);
    repeat (14) @(negedge clk);
    seen = txSeen;
    sendTok(2'd1);
    repeat (6) @(negedge clk);
    cmp("R9", "replyEn", 32'(replyEn), 0);
    cmp("R9", "inAck", 32'(inAck), 1);
    cmp("R9", "descAddr", 32'(descAddr), 32'h0408);
    cmp("R9", "descSize", 32'(descSize), 12);
    cmp("R9", "txSeen", 32'(txSeen), 32'(seen));
    wrReg(3'd5, 8'h01);

    // early end by a SETUP token before any data
    loadDesc(16'h0500, 16'd5);
    wrReg(3'd4, 8'h01);
    sendTok(2'd2);
    repeat (4) @(negedge clk);
    cmp("R9", "setup size", 32'(descSize), 5);
    cmp("R9", "setup replyEn", 32'(replyEn), 0);
    wrReg(3'd5, 8'h01);

    // single short packet
    loadDesc(16'h0600, 16'd3);
    wrReg(3'd4, 8'h01);
    sendTok(2'd0);
    repeat (8) @(negedge clk);
    cmp("R6", "short done", 32'(replyEn), 0);
    cmp("R6", "short addr", 32'(descAddr), 32'h0603);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule